// File: doc/BRIEF.md
# SPI Register Access Slave with Burst Transfers

This block lets an external SPI master read and write a small register file inside the chip. Every transaction opens with a command byte. The command byte gives the direction, an address-advance flag and a register address. Any number of data bytes follow for as long as slave select stays low. With the advance flag set, a burst walks through consecutive registers and wraps at the top of the address space. With the flag clear, every data byte uses the same register.

The SPI pins are oversampled in the system clock domain, so the whole block runs on one clock. Only SPI mode 0 is supported. The register array has a second port for on-chip logic. One address is a status register rather than a storage cell:

- On-chip writes set bits in it.
- SPI writes of 1 clear bits in it.
- One of its bits drives the interrupt request output.

Top module: `spireg_slave`

## Requirements
- R1: After synchronous reset, `miso`, `irq`, `loc_rdata` and every status bit are 0.
- R2: A command byte with bit 7 = 1 selects a write. Bits [5:0] hold the start address. Each complete data byte after the command is written to the register at the current address.
- R3: When command bit 6 = 1, the address rises by one after each data byte and wraps from 63 to 0. This holds for writes.
- R4: When command bit 6 = 0 in a write, every data byte goes to the start address, so the last byte wins and neighbouring registers keep their values.
- R5: A command with bit 7 = 0 selects a read. `miso` is 0 while `ss_n` is high and during the command byte. From the first data byte on, `miso` carries the addressed register MSB first. It changes only after a falling SCK edge, and the master samples it on the rising edge.
- R6: A read with command bit 6 = 1 returns consecutive registers in successive data bytes, wrapping from 63 to 0.
- R7: A read with command bit 6 = 0 returns the same register in every data byte.
- R8: Raising `ss_n` in mid-byte ends the transaction. A partly received data byte is never written, and the next transaction starts with a fresh command byte.
- R9: The local port writes a register when `loc_we` is 1. It returns the register at `loc_addr` on `loc_rdata` one clock later. Both ports see the same array.
- R10: Address 63 is the status register, and `irq` equals its bit 0. A local write ORs its data into the status register. An SPI write clears the bits where its data is 1. Both ports read the current status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock from the master (idle low) |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Slave select, active low |
| miso | output | 1 | Serial data to the master |
| irq | output | 1 | Interrupt request, level, from status bit 0 |
| loc_we | input | 1 | Local port write enable |
| loc_addr | input | 6 | Local port register address |
| loc_wdata | input | 8 | Local port write data |
| loc_rdata | output | 8 | Local port read data, one cycle latency |

## Verification
Writes are tried as a single byte, as an advancing burst that crosses the top of the address space, and as a fixed-address burst. Comparing their footprints in the array separates the increment and wrap logic from plain address decoding. Reads run the same three patterns against registers preloaded with distinct values, and the command byte's MISO value is checked too. This exposes off-by-one errors in prefetch timing and in bit ordering. Transfers cut off inside a data byte and inside a command byte check that no partial byte reaches the array and that framing restarts cleanly. Status set and clear sequences with mixed bit patterns separate the OR-set behaviour from the write-one-to-clear behaviour at the `irq` pin.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W      = 8;
  localparam int BIT_CNT_W   = $clog2(BYTE_W);
  localparam int CMD_DIR_BIT = 7;  // 1 = write, 0 = read
  localparam int CMD_INC_BIT = 6;  // 1 = advance address per data byte

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  input  logic ss_n,
  output logic mosi_s,
  output logic ss_on,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = 3 * STAGES;
  localparam logic [2:0] IDLE_V = 3'b100;  // {ss_n, mosi, sck}

  logic [CW-1:0] chain;
  logic [2:0]    tap;
  logic          sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_V}};
      sck_d <= 1'b0;
    end else begin
      chain <= {chain[CW-4:0], ss_n, mosi, sck};
      sck_d <= tap[0];
    end
  end

  assign tap     = chain[CW-1 -: 3];
  assign mosi_s  = tap[1];
  assign ss_on   = ~tap[2];
  assign rise_ev = ss_on & tap[0] & ~sck_d;
  assign fall_ev = ss_on & ~tap[0] & sck_d;
endmodule

// File: rtl/spireg_proto.sv
module spireg_proto
  import spireg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_on,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rdata,
  output logic              spi_we,
  output logic [AW-1:0]     op_addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              miso
);
  phase_t                 phase;
  logic [BIT_CNT_W-1:0]   bitcnt;
  logic [BYTE_W-1:0]      rx_sr, tx_buf, tx_sr;
  logic [BYTE_W-1:0]      byte_in;
  logic [AW-1:0]          cur, nxt;
  logic                   is_wr, inc, rd_pend, rd_go;

  assign byte_in = {rx_sr[BYTE_W-2:0], mosi_s};
  assign nxt     = inc ? cur + 1'b1 : cur;

  always_ff @(posedge clk) begin
    if (rst || !ss_on) begin
      phase   <= PH_CMD;
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      miso    <= 1'b0;
      spi_we  <= 1'b0;
      rd_go   <= 1'b0;
      rd_pend <= 1'b0;
      if (rst) begin
        tx_buf  <= '0;
        cur     <= '0;
        op_addr <= '0;
        wdata   <= '0;
        is_wr   <= 1'b0;
        inc     <= 1'b0;
      end
    end else begin
      spi_we  <= 1'b0;
      rd_go   <= 1'b0;
      rd_pend <= rd_go;
      if (rd_pend) tx_buf <= rdata;

      if (rise_ev) begin
        rx_sr  <= byte_in;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
          if (phase == PH_CMD) begin
            phase   <= PH_DATA;
            is_wr   <= byte_in[CMD_DIR_BIT];
            inc     <= byte_in[CMD_INC_BIT];
            cur     <= byte_in[AW-1:0];
            op_addr <= byte_in[AW-1:0];
            rd_go   <= ~byte_in[CMD_DIR_BIT];
          end else if (is_wr) begin
            spi_we  <= 1'b1;
            op_addr <= cur;
            wdata   <= byte_in;
            cur     <= nxt;
          end else begin
            cur     <= nxt;
            op_addr <= nxt;
            rd_go   <= 1'b1;
          end
        end
      end

      if (fall_ev) begin
        if (bitcnt == '0 && phase == PH_DATA && !is_wr) begin
          miso  <= tx_buf[BYTE_W-1];
          tx_sr <= {tx_buf[BYTE_W-2:0], 1'b0};
        end else begin
          miso  <= tx_sr[BYTE_W-1];
          tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spireg_regfile.sv
module spireg_regfile #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int STAT_ADDR = 63,
  parameter int IRQ_BIT   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          irq
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] stat, stat_clr, stat_set;

  assign stat_clr = (a_we && a_addr == STAT_A) ? a_wdata : '0;
  assign stat_set = (b_we && b_addr == STAT_A) ? b_wdata : '0;

  // Local port first, SPI port last: SPI wins a same-address collision.
  always_ff @(posedge clk) begin
    if (b_we && b_addr != STAT_A) mem[b_addr] <= b_wdata;
    if (a_we && a_addr != STAT_A) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat    <= '0;
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      stat    <= (stat & ~stat_clr) | stat_set;
      a_rdata <= (a_addr == STAT_A) ? stat : mem[a_addr];
      b_rdata <= (b_addr == STAT_A) ? stat : mem[b_addr];
    end
  end

  assign irq = stat[IRQ_BIT];
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave #(
  parameter int AW          = 6,
  parameter int STAT_ADDR   = 63,
  parameter int IRQ_BIT     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          mosi,
  input  logic          ss_n,
  output logic          miso,
  output logic          irq,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata
);
  logic          mosi_s, ss_on, rise_ev, fall_ev, spi_we;
  logic [AW-1:0] op_addr;
  logic [7:0]    spi_wdata, spi_rdata;

  spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .mosi_s(mosi_s), .ss_on(ss_on), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  spireg_proto #(.AW(AW)) u_proto (
    .clk(clk), .rst(rst), .ss_on(ss_on), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .mosi_s(mosi_s), .rdata(spi_rdata), .spi_we(spi_we), .op_addr(op_addr),
    .wdata(spi_wdata), .miso(miso)
  );

  spireg_regfile #(.AW(AW), .DW(8), .STAT_ADDR(STAT_ADDR), .IRQ_BIT(IRQ_BIT)) u_rf (
    .clk(clk), .rst(rst),
    .a_we(spi_we), .a_addr(op_addr), .a_wdata(spi_wdata), .a_rdata(spi_rdata),
    .b_we(loc_we), .b_addr(loc_addr), .b_wdata(loc_wdata), .b_rdata(loc_rdata),
    .irq(irq)
  );
endmodule

// File: rtl/spireg_chk.sv
module spireg_chk #(
  parameter int AW        = 6,
  parameter int STAT_ADDR = 63
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          miso,
  input logic          ss_on,
  input logic          rise_ev,
  input logic          fall_ev,
  input logic          spi_we,
  input logic          loc_we,
  input logic [AW-1:0] loc_addr,
  input logic          set_bit
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (loc_we && loc_addr == STAT_A && set_bit) |=> irq);  // R10
  AST_IRQ_ROSE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(loc_we && loc_addr == STAT_A && set_bit));  // R10
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(fall_ev) || $past(!ss_on)));  // R5
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(!ss_on) |-> !miso);  // R5
  AST_WR_NEEDS_SS: assert property (@(posedge clk) disable iff (rst)
    spi_we |-> $past(ss_on));  // R8
  AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    spi_we |-> $past(rise_ev));  // R2
endmodule

bind spireg_slave spireg_chk #(.AW(AW), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .miso(miso), .ss_on(ss_on),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .spi_we(spi_we),
  .loc_we(loc_we), .loc_addr(loc_addr), .set_bit(loc_wdata[IRQ_BIT])
);

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;
  localparam int H = 8;  // SCK half period in clk cycles

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic miso, irq, loc_we = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  int total = 0, bad = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  spireg_slave u0 (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .irq(irq), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic send_bit(input logic b, output logic m);
    mosi = b;
    wclk(H);
    m = miso;
    sck = 1'b1;
    wclk(H);
    sck = 1'b0;
  endtask

  // Full transaction: cmd in tx[0], n data bytes in tx[1..n]
  task automatic xfer(input int n);
    logic m;
    ss_n = 1'b0;
    wclk(H);
    for (int b = 0; b <= n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        send_bit(tx[b][i], m);
        rx[b][i] = m;
      end
    end
    wclk(H);
    ss_n = 1'b1;
    wclk(2 * H);
  endtask

  // Cut-off transaction: nbits bits of the serial stream tx[0], tx[1]
  task automatic partial(input int nbits);
    logic m;
    ss_n = 1'b0;
    wclk(H);
    for (int k = 0; k < nbits; k++) send_bit(tx[k / 8][7 - (k % 8)], m);
    wclk(H / 2);
    ss_n = 1'b1;
    wclk(2 * H);
  endtask

  task automatic lwr(input logic [5:0] a, input logic [7:0] d);
    loc_we = 1'b1; loc_addr = a; loc_wdata = d;
    wclk(1);
    loc_we = 1'b0;
  endtask

  task automatic lrd(input logic [5:0] a, output logic [7:0] d);
    loc_addr = a;
    wclk(1);
    d = loc_rdata;
  endtask

  task automatic t_reset();
    chk("R1 miso", {7'd0, miso}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 loc_rdata", loc_rdata, 8'd0);
    lrd(6'd63, rd); chk("R1 status", rd, 8'd0);
  endtask

  task automatic t_write_single();
    tx[0] = 8'h85; tx[1] = 8'h3C; xfer(1);
    lrd(6'd5, rd); chk("R2 single write", rd, 8'h3C);
  endtask

  task automatic t_write_inc();
    tx[0] = 8'hCA; tx[1] = 8'h11; tx[2] = 8'h22; tx[3] = 8'h33; xfer(3);
    lrd(6'd10, rd); chk("R3 burst reg10", rd, 8'h11);
    lrd(6'd11, rd); chk("R3 burst reg11", rd, 8'h22);
    lrd(6'd12, rd); chk("R3 burst reg12", rd, 8'h33);
    tx[0] = 8'hFE; tx[1] = 8'hA1; tx[2] = 8'h00; tx[3] = 8'hB2; xfer(3);
    lrd(6'd62, rd); chk("R3 wrap reg62", rd, 8'hA1);
    lrd(6'd0, rd);  chk("R3 wrap reg0", rd, 8'hB2);
  endtask

  task automatic t_write_fixed();
    lwr(6'd20, 8'h55); lwr(6'd21, 8'h55);
    tx[0] = 8'h94; tx[1] = 8'h01; tx[2] = 8'h02; tx[3] = 8'h03; xfer(3);
    lrd(6'd20, rd); chk("R4 last byte wins", rd, 8'h03);
    lrd(6'd21, rd); chk("R4 neighbour kept", rd, 8'h55);
  endtask

  task automatic t_read();
    lwr(6'd30, 8'hA5);
    tx[0] = 8'h1E; tx[1] = 8'h00; xfer(1);
    chk("R5 miso during cmd", rx[0], 8'h00);
    chk("R5 read data", rx[1], 8'hA5);
    chk("R5 miso idle", {7'd0, miso}, 8'd0);
  endtask

  task automatic t_read_inc();
    tx[0] = 8'h4A; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00; xfer(3);
    chk("R6 read reg10", rx[1], 8'h11);
    chk("R6 read reg11", rx[2], 8'h22);
    chk("R6 read reg12", rx[3], 8'h33);
    tx[0] = 8'h7E; xfer(3);
    chk("R6 wrap reg62", rx[1], 8'hA1);
    chk("R6 wrap status", rx[2], 8'h00);
    chk("R6 wrap reg0", rx[3], 8'hB2);
  endtask

  task automatic t_read_fixed();
    tx[0] = 8'h0B; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00; xfer(3);
    chk("R7 fixed byte1", rx[1], 8'h22);
    chk("R7 fixed byte2", rx[2], 8'h22);
    chk("R7 fixed byte3", rx[3], 8'h22);
  endtask

  task automatic t_abort();
    lwr(6'd40, 8'h77);
    tx[0] = 8'hA8; tx[1] = 8'hFF; partial(13);
    lrd(6'd40, rd); chk("R8 partial byte dropped", rd, 8'h77);
    tx[0] = 8'hA8; tx[1] = 8'h12; xfer(1);
    lrd(6'd40, rd); chk("R8 fresh command after abort", rd, 8'h12);
    tx[0] = 8'hA8; partial(4);
    tx[0] = 8'h28; tx[1] = 8'h00; xfer(1);
    chk("R8 cmd abort then read", rx[1], 8'h12);
  endtask

  task automatic t_local();
    lwr(6'd50, 8'h9E);
    lrd(6'd50, rd); chk("R9 local readback", rd, 8'h9E);
    tx[0] = 8'h32; tx[1] = 8'h00; xfer(1);
    chk("R9 shared with SPI", rx[1], 8'h9E);
  endtask

  task automatic t_status();
    lwr(6'd63, 8'h05);
    chk("R10 irq set", {7'd0, irq}, 8'd1);
    lrd(6'd63, rd); chk("R10 status or-set", rd, 8'h05);
    tx[0] = 8'hBF; tx[1] = 8'h04; xfer(1);
    chk("R10 irq kept", {7'd0, irq}, 8'd1);
    lrd(6'd63, rd); chk("R10 clear bit2", rd, 8'h01);
    tx[0] = 8'hBF; tx[1] = 8'h01; xfer(1);
    chk("R10 irq cleared", {7'd0, irq}, 8'd0);
    lwr(6'd63, 8'h02);
    chk("R10 irq not set by bit1", {7'd0, irq}, 8'd0);
    tx[0] = 8'h3F; tx[1] = 8'h00; xfer(1);
    chk("R10 spi status read", rx[1], 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    wclk(4);
    rst = 1'b0;
    wclk(2);
    t_reset();
    t_write_single();
    t_write_inc();
    t_write_fixed();
    t_read();
    t_read_inc();
    t_read_fixed();
    t_abort();
    t_local();
    t_status();
    summary();
  end
endmodule